// File: doc/BRIEF.md
# Serial Sampling Converter Frame Controller

This block is the digital side of a two-channel, 12-bit serial sampling converter. The analog core is replaced by one parallel sample bus per channel. The block runs on the serial clock and samples the active-low chip select on each active clock edge. On the edge where chip select is first seen low, it captures the sample of the chosen channel and starts a frame. Each later edge shifts out one more bit of the frame. The output is a serial data bit together with a drive-enable, which stands in for a three-state data pin.

The edge at which chip select returns high sets the power state. If a frame ends early, the block drops into power-down. If a frame runs long enough, the block stays in normal mode. A frame that starts while the block is powered down is a wake-up frame: its data is discarded, and it restores normal mode only if it runs long enough. The channel select is read late in a frame and takes effect at the next capture. This lets a host alternate channels on every frame.

Top module: `adc_frame_top`

## Requirements
- R1: While chip select is high, and after reset, `dataOe` is 0. `dataOe` falls as soon as chip select rises, without waiting for a clock edge.
- R2: The edge at which chip select is first seen low is the start edge. After it, `dataOut` carries a leading 0. After the k-th following edge (k = 1..12), it carries captured bit 12-k, so the MSB comes first. After the 13th and 14th edges, it carries 0.
- R3: After the 15th edge following the start edge, `dataOe` stays 0 for the rest of that low period.
- R4: The sample is taken at the start edge. Changes to either sample bus after that edge do not alter the frame.
- R5: If chip select is seen high when fewer than 10 edges have followed the start edge, the block enters power-down (`powerDown` = 1).
- R6: If chip select rises after 10 or more edges have followed the start edge, a block that was in normal mode stays in normal mode.
- R7: A frame started in power-down is a dummy frame. It shifts all zeros and keeps `frameValid` at 0. Its 10th edge after the start clears `powerDown`, and the next frame is valid.
- R8: A dummy frame that ends before its 10th edge leaves the block in power-down.
- R9: `chSel` = 0 selects `sampleA` and `chSel` = 1 selects `sampleB`. The level is latched at the 12th edge after a start edge and used at the next start edge. A frame that ends before its 12th edge does not change the channel. After reset, channel A is selected.
- R10: `frameValid` is 1 during every frame started in normal mode.
- R11: A 14-cycle frame (chip select high for a single edge after the 13th edge) leaves normal mode intact. The next frame starts on the following low edge with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; the rising edge is the active edge |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Active-low chip select |
| chSel | input | 1 | Channel select (0 = A, 1 = B) |
| sampleA | input | 12 | Parallel sample of channel A |
| sampleB | input | 12 | Parallel sample of channel B |
| dataOut | output | 1 | Serial data bit |
| dataOe | output | 1 | Drive enable of the serial data pin |
| powerDown | output | 1 | Power-down state |
| frameValid | output | 1 | Current frame carries a valid result |

## Verification
Frames are run with chosen low lengths: full 16-cycle frames, overlong frames, 14-cycle back-to-back frames, and frames cut short at 3, 5 and 11 edges. The long frames show the bit order and the return to high impedance. The short frames separate the power-down threshold at 10 edges from the channel latch at 12 edges. A wake-up sequence checks that an aborted dummy frame keeps the block asleep, while a full dummy frame wakes it. Random frames then vary low length, channel and sample values together, so that errors in the power state and in channel tracking add up across frames.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  typedef struct packed {
    logic load;
    logic shift;
    logic dummy;
  } frame_strobe_t;
endpackage

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
  parameter int DATA_W = 12,
  parameter int WAKE_EDGE = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic csN,
  input  logic chSel,
  output adc_frame_pkg::frame_strobe_t strobe,
  output logic chLat,
  output logic dataOe,
  output logic powerDown,
  output logic frameValid
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] WAKE = CNT_W'(WAKE_EDGE);
  localparam logic [CNT_W-1:0] CH_EDGE = CNT_W'(DATA_W);

  logic csQ;
  logic dummyQ;
  logic [CNT_W-1:0] cnt;
  logic startEdge, running, ending;

  assign startEdge = ~csN & csQ;
  assign running = ~csN & ~csQ;
  assign ending = csN & ~csQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      csQ <= 1'b1;
      cnt <= '0;
      powerDown <= 1'b0;
      dummyQ <= 1'b0;
      chLat <= 1'b0;
    end else begin
      csQ <= csN;
      if (startEdge) begin
        cnt <= '0;
        dummyQ <= powerDown;
      end else if (running) begin
        if (cnt != LAST) cnt <= cnt + 1'b1;
        if (powerDown && cnt == WAKE - 1'b1) powerDown <= 1'b0;
        if (cnt == CH_EDGE - 1'b1) chLat <= chSel;
      end else if (ending) begin
        if (cnt < WAKE) powerDown <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load = startEdge;
    strobe.shift = running;
    strobe.dummy = powerDown;
  end

  assign dataOe = running & (cnt != LAST);
  assign frameValid = running & ~dummyQ;

  a_r5_early_rise_sleeps: assert property (@(posedge clk) disable iff (rst)
    (ending && cnt < WAKE) |=> powerDown);
  a_r6_late_rise_keeps: assert property (@(posedge clk) disable iff (rst)
    (ending && cnt >= WAKE && !powerDown) |=> !powerDown);
  a_r7_wake_at_edge: assert property (@(posedge clk) disable iff (rst)
    (running && powerDown && cnt == WAKE - 1'b1) |=> !powerDown);
  a_r3_count_holds: assert property (@(posedge clk) disable iff (rst)
    (running && cnt == LAST) |=> (cnt == LAST));
  a_r9_channel_latch: assert property (@(posedge clk) disable iff (rst)
    (running && cnt == CH_EDGE - 1'b1) |=> (chLat == $past(chSel)));
endmodule

// File: rtl/adc_frame_dp.sv
module adc_frame_dp #(
  parameter int DATA_W = 12
) (
  input  logic clk,
  input  logic rst,
  input  adc_frame_pkg::frame_strobe_t strobe,
  input  logic chLat,
  input  logic [DATA_W-1:0] sampleA,
  input  logic [DATA_W-1:0] sampleB,
  output logic dataOut
);
  localparam int FRAME_W = DATA_W + 3;

  logic [FRAME_W-1:0] shReg;
  logic [DATA_W-1:0] chosen;

  assign chosen = chLat ? sampleB : sampleA;

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg <= '0;
    end else if (strobe.load) begin
      shReg <= strobe.dummy ? '0 : {1'b0, chosen, 2'b00};
    end else if (strobe.shift) begin
      shReg <= {shReg[FRAME_W-2:0], 1'b0};
    end
  end

  assign dataOut = shReg[FRAME_W-1];

  a_r2_lead_zero: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> !shReg[FRAME_W-1]);
endmodule

// File: rtl/adc_frame_top.sv
module adc_frame_top #(
  parameter int DATA_W = 12,
  parameter int WAKE_EDGE = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic csN,
  input  logic chSel,
  input  logic [DATA_W-1:0] sampleA,
  input  logic [DATA_W-1:0] sampleB,
  output logic dataOut,
  output logic dataOe,
  output logic powerDown,
  output logic frameValid
);
  adc_frame_pkg::frame_strobe_t strobe;
  logic chLat;

  adc_frame_ctrl #(.DATA_W(DATA_W), .WAKE_EDGE(WAKE_EDGE)) u_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .chSel(chSel),
    .strobe(strobe), .chLat(chLat), .dataOe(dataOe),
    .powerDown(powerDown), .frameValid(frameValid)
  );

  adc_frame_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .chLat(chLat),
    .sampleA(sampleA), .sampleB(sampleB), .dataOut(dataOut)
  );
endmodule

// File: tb/adc_frame_top_test.sv
module adc_frame_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1;
  logic chSel = 1'b0;
  logic [11:0] sampleA = '0;
  logic [11:0] sampleB = '0;
  logic dataOut, dataOe, powerDown, frameValid;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  bit mPwr = 0;
  bit mCh = 0;

  always #10 clk = ~clk;

  adc_frame_top uut (
    .clk(clk), .rst(rst), .csN(csN), .chSel(chSel),
    .sampleA(sampleA), .sampleB(sampleB),
    .dataOut(dataOut), .dataOe(dataOe),
    .powerDown(powerDown), .frameValid(frameValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic expBit(input int k, input logic [11:0] word);
    if (k >= 1 && k <= 12) return word[12-k];
    return 1'b0;
  endfunction

  task automatic runFrame(input int nLow, input logic ch);
    logic [11:0] a, b, expWord;
    bit dum;
    @(negedge clk);
    a = 12'($urandom);
    b = 12'($urandom);
    sampleA = a;
    sampleB = b;
    chSel = ch;
    csN = 1'b0;
    dum = mPwr;
    expWord = dum ? 12'h000 : (mCh ? b : a);
    for (int k = 0; k <= nLow; k++) begin
      @(posedge clk);
      #1;
      if (k == 0) begin
        sampleA = ~a;  // R4: later bus changes must not reach the frame
        sampleB = ~b;
      end
      check(k < 15 ? "R2 oe" : "R3 oe", 32'(dataOe), 32'(k < 15));
      if (k < 15) check(dum ? "R7 dummy data" : "R2/R4 data", 32'(dataOut), 32'(expBit(k, expWord)));
      check(dum ? "R7 valid" : "R10 valid", 32'(frameValid), 32'(!dum));
    end
    @(negedge clk);
    csN = 1'b1;
    #1;
    check("R1 oe on rise", 32'(dataOe), 32'd0);
    if (nLow < 10) mPwr = 1;
    else mPwr = 0;
    if (nLow >= 12) mCh = ch;
    @(posedge clk);
    #1;
    check(nLow < 10 ? (dum ? "R8 power" : "R5 power") : (dum ? "R7 wake" : "R6 power"),
          32'(powerDown), 32'(mPwr));
    check("R1 oe idle", 32'(dataOe), 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset oe", 32'(dataOe), 32'd0);
    check("R11 reset power", 32'(powerDown), 32'd0);
    check("R10 reset valid", 32'(frameValid), 32'd0);
    runFrame(15, 1'b0);   // R2 full frame, channel A
    runFrame(17, 1'b1);   // R3 overlong, latch B (R9)
    runFrame(15, 1'b0);   // R9 uses B, latch A
    runFrame(11, 1'b1);   // R9 no latch before 12th edge
    runFrame(15, 1'b0);   // R9 still channel A
    runFrame(13, 1'b0);   // R11 14-cycle frames back to back
    runFrame(13, 1'b0);
    runFrame(5, 1'b0);    // R5 early rise
    runFrame(3, 1'b0);    // R8 aborted dummy
    runFrame(10, 1'b0);   // R7 wake on 10th edge
    runFrame(15, 1'b0);   // R7 next frame valid
    runFrame(9, 1'b0);    // R5 boundary
    runFrame(10, 1'b0);   // R7 wake
    runFrame(10, 1'b1);   // R6 boundary
    for (int i = 0; i < 80; i++) runFrame(int'($urandom_range(0, 17)), 1'($urandom));
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule